// File: doc/BRIEF.md
# Sliding Window Histogram Updater

This block keeps a running histogram of the most recent `WIN` pixels of an 8-bit gray-level stream. There is one bin for each of the 256 gray levels. Each bin holds the number of times its level occurs inside the window. The histogram is never recomputed over the whole window. Each accepted pixel costs exactly one increment and at most one decrement, and both are carried out in the same cycle through two write ports of the bin memory.

To learn which value drops out of the window, the block keeps a delay line of the last `WIN` accepted pixels. Each bin update is a read-modify-write:

- The bins are read on the cycle the pixel is accepted.
- They are written back on the next cycle.
- A write-first bypass on the read side covers back-to-back pixels that touch the same bin.

After reset, the block first zeroes all 256 bins, one bin per cycle, and only then raises `ready`. A separate registered read port returns the count of any bin to the consumer of the histogram.

Top module: `slide_hist`

## Requirements
- R1: After reset `ready` is low and `rd_count` is 0. The block writes zero to all 256 bins, one per cycle, then raises `ready` and keeps it high until the next reset. Every bin then reads 0.
- R2: A pixel presented with `pix_valid` high while `ready` is low is ignored. It changes no bin and does not enter the window.
- R3: Each pixel accepted (`pix_valid` and `ready` high at a clock edge) increments the bin whose index equals its 8-bit value.
- R4: While fewer than `WIN` pixels have been accepted since reset, no bin is decremented.
- R5: Once `WIN` pixels have been accepted, each new accepted pixel decrements the bin of the pixel accepted `WIN` pixels before it.
- R6: When the departing and arriving values are equal, that bin keeps its count and the two write ports never target the same bin.
- R7: Pixels on consecutive cycles that touch the same bin (as arriving or departing value) are all counted, with no lost update.
- R8: The count sampled into `rd_count` at a clock edge is that of bin `rd_bin` at that edge. It includes every pixel accepted at least two edges earlier.
- R9: Counts stay within 0..`WIN` and are `ceil(log2(WIN+1))` bits wide. A bin at `WIN` is never incremented and a bin at 0 is never decremented.
- R10: Cycles with `pix_valid` low neither shift the window nor change any bin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Pixel strobe |
| pix_in | input | 8 | Incoming gray level |
| ready | output | 1 | High once the clear pass is done; pixels are accepted only then |
| rd_bin | input | 8 | Bin index to read |
| rd_count | output | CNT_W | Registered count of bin `rd_bin` |

## Verification
A pixel sampled at clock edge k has its bins read at edge k and written at edge k+1. A read address presented at edge k+2 therefore returns a count that includes that pixel, and this count is visible after edge k+2.

The driver records the cycle in which it presents each pixel, together with the bin it wants probed and the count a reference model predicts. The monitor drives that bin onto `rd_bin` two cycles later and compares `rd_count` one cycle after that, always on the falling edge.

The `ready` timing around the 256-cycle clear pass is checked with plain waits.

// File: rtl/slide_hist_pkg.sv
// Package: shared constants and the per-pixel update record.
package slide_hist_pkg;
    localparam int PIX_W = 8;
    localparam int NBINS = 1 << PIX_W;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        logic inc_en;
        logic dec_en;
        pix_t inc_bin;
        pix_t dec_bin;
    } upd_t;
endpackage

// File: rtl/sh_pix_delay.sv
// Module: pixel delay line of WIN stages plus fill counter.
// Shifts on push only; `oldest` is the value accepted WIN pushes ago once
// `full` is high. Assumes WIN >= 1.
module sh_pix_delay
    import slide_hist_pkg::*;
#(
    parameter int WIN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  pix_t din,
    output pix_t oldest,
    output logic full
);
    localparam int FILL_W = $clog2(WIN + 1);

    pix_t              tap [WIN];
    logic [FILL_W-1:0] fill;

    // First stage takes the incoming pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)    tap[0] <= '0;
        else if (push) tap[0] <= din;
    end

    genvar gi;
    generate
        for (gi = 1; gi < WIN; gi++) begin : g_stage
            // Each later stage takes its predecessor on push.
            always_ff @(posedge clk) begin
                if (!rst_n)    tap[gi] <= '0;
                else if (push) tap[gi] <= tap[gi-1];
            end
        end
    endgenerate

    // Counts accepted pixels until the line holds a full window.
    always_ff @(posedge clk) begin
        if (!rst_n)                                fill <= '0;
        else if (push && fill != FILL_W'(WIN))     fill <= fill + 1'b1;
    end

    assign oldest = tap[WIN-1];
    assign full   = (fill == FILL_W'(WIN));

    assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> full)
        else $error("window fill dropped without reset");
endmodule

// File: rtl/sh_clear_seq.sv
// Module: post-reset clear sequencer.
// Walks every bin index once, requesting a zero write each cycle, then
// raises `ready` and holds it until the next reset.
module sh_clear_seq
    import slide_hist_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic clr_we,
    output pix_t clr_bin,
    output logic ready
);
    pix_t idx;

    // Advances the clear index and flags completion after the last bin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            idx <= idx + 1'b1;
            if (idx == pix_t'(NBINS - 1)) ready <= 1'b1;
        end
    end

    assign clr_we  = !ready;
    assign clr_bin = idx;

    assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready)
        else $error("ready fell without reset");
endmodule

// File: rtl/sh_bin_ram.sv
// Module: bin storage with two write ports and two registered read ports.
// The read ports bypass same-cycle writes (write-first), so a read issued
// while an earlier update commits returns the new count. A third registered
// read port, without bypass, serves external queries.
module sh_bin_ram
    import slide_hist_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_a,
    input  pix_t             wa,
    input  logic [CNT_W-1:0] wd_a,
    input  logic             we_b,
    input  pix_t             wb,
    input  logic [CNT_W-1:0] wd_b,
    input  pix_t             ra,
    input  pix_t             rb,
    output logic [CNT_W-1:0] qa,
    output logic [CNT_W-1:0] qb,
    input  pix_t             rq,
    output logic [CNT_W-1:0] qq
);
    logic [CNT_W-1:0] mem [NBINS];

    function automatic logic [CNT_W-1:0] fwd(input pix_t adr, input logic [CNT_W-1:0] stored,
                                             input logic ea, input pix_t aa, input logic [CNT_W-1:0] da,
                                             input logic eb, input pix_t ab, input logic [CNT_W-1:0] db);
        if (ea && aa == adr)      return da;
        else if (eb && ab == adr) return db;
        else                      return stored;
    endfunction

    // Commits both write ports.
    always_ff @(posedge clk) begin
        if (we_a) mem[wa] <= wd_a;
        if (we_b) mem[wb] <= wd_b;
    end

    // Registers the two update reads with write-first bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qa <= '0;
            qb <= '0;
        end else begin
            qa <= fwd(ra, mem[ra], we_a, wa, wd_a, we_b, wb, wd_b);
            qb <= fwd(rb, mem[rb], we_a, wa, wd_a, we_b, wb, wd_b);
        end
    end

    // Registers the query read.
    always_ff @(posedge clk) begin
        if (!rst_n) qq <= '0;
        else        qq <= mem[rq];
    end

    assert_port_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a && we_b) |-> (wa != wb))
        else $error("both write ports hit one bin");
endmodule

// File: rtl/slide_hist.sv
// Module: sliding-window histogram top.
// Stage 1 (accept edge): reads the arriving and departing bins and records
// which of them to touch. Stage 2 (next edge): writes count+1 and count-1.
// Assumes WIN >= 1; pixels are taken only while `ready` is high.
module slide_hist
    import slide_hist_pkg::*;
#(
    parameter  int WIN   = 5,
    localparam int CNT_W = $clog2(WIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [7:0]       pix_in,
    output logic             ready,
    input  logic [7:0]       rd_bin,
    output logic [CNT_W-1:0] rd_count
);
    logic             accept, full, same, clr_we;
    pix_t             oldest, clr_bin;
    upd_t             upd_d, upd_q;
    logic             we_a, we_b;
    pix_t             wa;
    logic [CNT_W-1:0] wd_a, wd_b, qa, qb;

    assign accept = pix_valid && ready;
    assign same   = full && (oldest == pix_in);

    sh_pix_delay #(.WIN(WIN)) u_delay (
        .clk(clk), .rst_n(rst_n), .push(accept), .din(pix_in),
        .oldest(oldest), .full(full)
    );

    sh_clear_seq u_clear (
        .clk(clk), .rst_n(rst_n), .clr_we(clr_we), .clr_bin(clr_bin), .ready(ready)
    );

    // Builds this pixel's update: skip both sides when values match.
    always_comb begin
        upd_d.inc_en  = accept && !same;
        upd_d.dec_en  = accept && full && !same;
        upd_d.inc_bin = pix_in;
        upd_d.dec_bin = oldest;
    end

    // Holds the update for the write-back stage.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= '0;
        else        upd_q <= upd_d;
    end

    // Port A serves the clear pass first, then increments; port B decrements.
    always_comb begin
        we_a = clr_we ? 1'b1    : upd_q.inc_en;
        wa   = clr_we ? clr_bin : upd_q.inc_bin;
        wd_a = clr_we ? '0      : qa + 1'b1;
        we_b = upd_q.dec_en;
        wd_b = qb - 1'b1;
    end

    sh_bin_ram #(.CNT_W(CNT_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we_a(we_a), .wa(wa), .wd_a(wd_a),
        .we_b(we_b), .wb(upd_q.dec_bin), .wd_b(wd_b),
        .ra(pix_in), .rb(oldest), .qa(qa), .qb(qb),
        .rq(rd_bin), .qq(rd_count)
    );

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q.inc_en |-> (qa < CNT_W'(WIN)))
        else $error("increment of a full bin");

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q.dec_en |-> (qb != '0))
        else $error("decrement of an empty bin");

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !(upd_q.inc_en || upd_q.dec_en))
        else $error("update without an accepted pixel");

    assert_no_early_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !full |=> !upd_q.dec_en)
        else $error("decrement before the window filled");
endmodule

// File: tb/slide_hist_test.sv
// Scoreboard bench: the driver presents pixels and queues bin probes with
// model-predicted counts; the monitor issues and checks them in due cycles.
module slide_hist_test;
    localparam int WIN   = 5;
    localparam int CNT_W = $clog2(WIN + 1);

    typedef struct {
        logic [7:0]  addr;
        int          exp;
        int          c;
        logic [23:0] tag;
    } probe_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pix_valid = 1'b0;
    logic [7:0]       pix_in = '0;
    logic             ready;
    logic [7:0]       rd_bin = '0;
    logic [CNT_W-1:0] rd_count;

    int     cyc = 0;
    int     checks = 0;
    int     errors = 0;
    bit     done = 0;
    int     model [256];
    int     win_q [$];
    probe_t adr_q [$];
    probe_t chk_q [$];
    probe_t mon_e;

    slide_hist #(.WIN(WIN)) uut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_in(pix_in),
        .ready(ready), .rd_bin(rd_bin), .rd_count(rd_count)
    );

    always #2 clk = ~clk;   // 4 ns period

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic [23:0] tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle per call; updates the model and queues a probe.
    task automatic step(input logic v, input logic [7:0] p, input logic pr,
                        input logic [7:0] pa, input logic [23:0] tag);
        @(negedge clk);
        pix_valid = v;
        pix_in    = p;
        if (v && ready) begin
            if (win_q.size() == WIN) model[win_q.pop_front()]--;
            win_q.push_back(int'(p));
            model[p]++;
        end
        if (pr) adr_q.push_back('{pa, model[pa], cyc, tag});
    endtask

    task automatic drain();
        while (adr_q.size() > 0 || chk_q.size() > 0) step(1'b0, 8'd0, 1'b0, 8'd0, "R8");
    endtask

    task automatic do_reset();
        drain();
        @(negedge clk);
        rst_n = 1'b0;
        pix_valid = 1'b0;
        repeat (3) @(negedge clk);
        foreach (model[i]) model[i] = 0;
        win_q.delete();
        check("R1", int'(rd_count), 0, "rd_count in reset");
        check("R1", int'(ready), 0, "ready in reset");
        rst_n = 1'b1;
    endtask

    // Monitor: checks due probes, then presents the next read address.
    always @(negedge clk) begin
        if (chk_q.size() > 0 && chk_q[0].c + 3 == cyc) begin
            mon_e = chk_q.pop_front();
            check(mon_e.tag, int'(rd_count), mon_e.exp, $sformatf("bin %0d", mon_e.addr));
        end
        if (adr_q.size() > 0 && adr_q[0].c + 2 == cyc) begin
            mon_e = adr_q.pop_front();
            rd_bin = mon_e.addr;
            chk_q.push_back(mon_e);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();
        // R2: pixels during the clear pass are dropped.
        step(1'b1, 8'd7, 1'b0, 8'd0, "R2");
        step(1'b1, 8'd7, 1'b0, 8'd0, "R2");
        step(1'b1, 8'd9, 1'b0, 8'd0, "R2");
        step(1'b0, 8'd0, 1'b0, 8'd0, "R2");
        repeat (200) @(negedge clk);
        check("R1", int'(ready), 0, "ready still low mid-clear");
        repeat (60) @(negedge clk);
        check("R1", int'(ready), 1, "ready after clear");
        step(1'b0, 8'd0, 1'b1, 8'd7,   "R2");
        step(1'b0, 8'd0, 1'b1, 8'd9,   "R2");
        step(1'b0, 8'd0, 1'b1, 8'd255, "R1");
        step(1'b0, 8'd0, 1'b1, 8'd0,   "R1");

        // Worked-window case: 108 leaves when 103 enters, then 1 leaves for 113.
        step(1'b1, 8'd108, 1'b1, 8'd108, "R3");
        step(1'b1, 8'd1,   1'b1, 8'd1,   "R3");
        step(1'b1, 8'd2,   1'b1, 8'd108, "R4");
        step(1'b1, 8'd3,   1'b1, 8'd2,   "R4");
        step(1'b1, 8'd4,   1'b1, 8'd108, "R4");
        step(1'b1, 8'd103, 1'b1, 8'd108, "R5");
        step(1'b1, 8'd113, 1'b1, 8'd1,   "R5");
        step(1'b0, 8'd0,   1'b1, 8'd103, "R3");
        step(1'b0, 8'd0,   1'b1, 8'd113, "R3");

        // Same value back to back: saturates at WIN and holds.
        for (int i = 0; i < 9; i++) step(1'b1, 8'd50, 1'b1, 8'd50, (i < 5) ? "R7" : "R6");
        step(1'b0, 8'd0, 1'b1, 8'd50, "R9");
        step(1'b0, 8'd0, 1'b1, 8'd3,  "R5");

        // Alternating pair: arriving and departing bins collide every cycle.
        for (int i = 0; i < 12; i++)
            step(1'b1, (i % 2) ? 8'd60 : 8'd61, 1'b1, (i % 3 == 0) ? 8'd50 : ((i % 2) ? 8'd61 : 8'd60), "R7");

        // Gaps: idle cycles do not shift the window.
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 8'(20 + i), 1'b1, 8'(20 + i), "R10");
            step(1'b0, 8'd0, 1'b1, (i >= 5) ? 8'(15 + i) : 8'd61, "R10");
        end

        // Mixed stream over a narrow value range.
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[5], 8'(40 + lfsr[2:0]), 1'b1, 8'(40 + lfsr[9:7]), "R8");
        end

        // Second reset wipes populated bins; refill does no early decrement.
        do_reset();
        while (!ready) step(1'b0, 8'd0, 1'b0, 8'd0, "R1");
        step(1'b0, 8'd0, 1'b1, 8'd41, "R1");
        step(1'b0, 8'd0, 1'b1, 8'd42, "R1");
        for (int i = 0; i < 7; i++) step(1'b1, 8'd77, 1'b1, 8'd77, (i < 5) ? "R4" : "R6");
        drain();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule